// File: doc/BRIEF.md
# Dual Auto-Reload Timer with Shared Prescaler

This block provides a set of identical 16-bit timer channels (two by default) for a small microcontroller. All channels share one prescaler. The prescaler divides the system clock by 4, 16 or 64 and produces a one-cycle count tick. A channel that is running advances on each tick.

Each channel has a 16-bit count, a 16-bit reload value and a control byte. The control byte holds the run bit, the mode and the overflow flag. Software programs everything through a byte-wide write port with a strobe, an address and data.

Four counting modes are available:
- a 16-bit count that reloads from the reload register on overflow;
- a free-running 16-bit count that wraps to zero;
- an 8-bit count in the low byte that reloads from the low reload byte while the high byte stays untouched;
- a hold mode that does not count.

The live count and the overflow flag of every channel drive output ports.

Top module: `tmr_pair`

## Requirements
- R1: The select field (address 0, data bits 1:0) sets the tick period: 00 gives one tick every 4 cycles, 01 every 16, 10 every 64, and 11 behaves as 00. The tick is high for exactly one cycle per period.
- R2: All channels advance on the same shared tick. Two channels set up identically end up with equal counts.
- R3: Mode 00 (control bits 2:1) counts up by one per tick. On the tick where the count is 0xFFFF, it loads the 16-bit reload value and sets the overflow flag.
- R4: Mode 01 counts up by one per tick and wraps from 0xFFFF to 0x0000 without reloading, setting the overflow flag on the wrap.
- R5: Mode 10 counts only the low byte. When the low byte is 0xFF it loads the low reload byte and sets the overflow flag. The high count byte never changes while counting.
- R6: Mode 11 holds the count unchanged on every tick.
- R7: A channel counts only while its run bit (control bit 0) is 1. With the run bit at 0 the count stays unchanged.
- R8: The overflow flag (control bit 3) stays set until a control write with bit 3 at 0. Writing 1 to bit 3 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: A write to a count byte (offset 2 low, offset 3 high) takes effect on the next cycle, replaces that byte and suppresses the increment of that cycle.
- R10: After reset all counts, reload values, run bits and flags are 0, the mode is 00 and the select field is 00.
- R11: Channel n occupies addresses 8n+1 (control), 8n+2/8n+3 (count low/high) and 8n+4/8n+5 (reload low/high). Writes to any other offset in the window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W (4) | Write address |
| wr_data_i | input | 8 | Write data |
| tick_o | output | 1 | Shared prescaler tick |
| count_o | output | 16*NCH | Channel counts, channel 0 in the low bits |
| ovf_o | output | NCH | Channel overflow flags |

## Verification
A table of vectors runs both channels side by side. It covers:
- every mode and every select code;
- start values just below the wrap point, so the reload, wrap and 8-bit reload paths each fire once inside the window;
- a start value far from it, so a spurious overflow would show.

The reference result follows from the number of ticks seen at the port. This separates a wrong reload source from a wrong wrap or a drifting high byte, and it separates a wrong divide ratio from a channel-local error. Directed cases then place a clearing write and a count write exactly on a tick edge, to show which side wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_RLD16 = 2'b00,
        MODE_FREE16 = 2'b01,
        MODE_RLD8 = 2'b10,
        MODE_HOLD = 2'b11
    } tmr_mode_e;

    localparam logic [2:0] OFS_PSEL   = 3'd0;
    localparam logic [2:0] OFS_CTRL   = 3'd1;
    localparam logic [2:0] OFS_CNT_LO = 3'd2;
    localparam logic [2:0] OFS_CNT_HI = 3'd3;
    localparam logic [2:0] OFS_RLD_LO = 3'd4;
    localparam logic [2:0] OFS_RLD_HI = 3'd5;

    typedef struct packed {
        logic [15:0] count;
        logic [15:0] reload;
        tmr_mode_e   mode;
        logic        run;
        logic        ovf;
    } chan_st_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr_i,
    input  logic [1:0] sel_data_i,
    output logic       tick_o
);
    localparam logic [DIV_W-1:0] LIM_4  = DIV_W'(3);
    localparam logic [DIV_W-1:0] LIM_16 = DIV_W'(15);
    localparam logic [DIV_W-1:0] LIM_64 = DIV_W'(63);

    typedef struct packed {
        logic [1:0]       sel;
        logic [DIV_W-1:0] div;
    } ps_st_t;

    ps_st_t           st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        case (st_q.sel)
            2'b01:   lim = LIM_16;
            2'b10:   lim = LIM_64;
            default: lim = LIM_4;
        endcase
        tick_o = (st_q.div >= lim);
        st_d.div = tick_o ? '0 : st_q.div + 1'b1;
        if (sel_wr_i) st_d.sel = sel_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a tick never lasts longer than one cycle
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_i,
    input  logic [2:0]  wr_ofs_i,
    input  logic [7:0]  wr_data_i,
    output logic [15:0] count_o,
    output logic        ovf_o
);
    chan_st_t st_d, st_q;
    logic ctrl_wr, lo_wr, hi_wr, cnt_wr, step, ovf_evt;

    always_comb begin
        ctrl_wr = wr_i && (wr_ofs_i == OFS_CTRL);
        lo_wr   = wr_i && (wr_ofs_i == OFS_CNT_LO);
        hi_wr   = wr_i && (wr_ofs_i == OFS_CNT_HI);
        cnt_wr  = lo_wr || hi_wr;
        step    = tick_i && st_q.run && !cnt_wr;
        ovf_evt = 1'b0;
        st_d    = st_q;

        if (step) begin
            case (st_q.mode)
                MODE_RLD16: begin
                    if (st_q.count == 16'hFFFF) begin
                        st_d.count = st_q.reload;
                        ovf_evt    = 1'b1;
                    end else begin
                        st_d.count = st_q.count + 16'd1;
                    end
                end
                MODE_FREE16: begin
                    st_d.count = st_q.count + 16'd1;
                    ovf_evt    = (st_q.count == 16'hFFFF);
                end
                MODE_RLD8: begin
                    if (st_q.count[7:0] == 8'hFF) begin
                        st_d.count[7:0] = st_q.reload[7:0];
                        ovf_evt         = 1'b1;
                    end else begin
                        st_d.count[7:0] = st_q.count[7:0] + 8'd1;
                    end
                end
                default: ;
            endcase
        end

        if (lo_wr) st_d.count[7:0]  = wr_data_i;
        if (hi_wr) st_d.count[15:8] = wr_data_i;
        if (wr_i && wr_ofs_i == OFS_RLD_LO) st_d.reload[7:0]  = wr_data_i;
        if (wr_i && wr_ofs_i == OFS_RLD_HI) st_d.reload[15:8] = wr_data_i;
        if (ctrl_wr) begin
            st_d.run  = wr_data_i[0];
            st_d.mode = tmr_mode_e'(wr_data_i[2:1]);
        end

        if (ovf_evt)                      st_d.ovf = 1'b1;
        else if (ctrl_wr && !wr_data_i[3]) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;

    // R7
    a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !cnt_wr) |=> st_q.count == $past(st_q.count));
    // R3
    a_r3_reload16: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.run && !cnt_wr && st_q.mode == MODE_RLD16 && st_q.count == 16'hFFFF)
        |=> (st_q.count == $past(st_q.reload)) && st_q.ovf);
    // R5
    a_r5_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RLD8 && !hi_wr) |=> st_q.count[15:8] == $past(st_q.count[15:8]));
    // R6
    a_r6_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_HOLD && !cnt_wr) |=> $stable(st_q.count));
    // R8
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !(ctrl_wr && !wr_data_i[3])) |=> st_q.ovf);
    // R9
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> st_q.count[7:0] == $past(wr_data_i));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DIV_W = 6,
    localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = CH_IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              tick_o,
    output logic [16*NCH-1:0] count_o,
    output logic [NCH-1:0]    ovf_o
);
    logic psel_wr;

    assign psel_wr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_PSEL));

    tmr_prescale #(.DIV_W(DIV_W)) u_ps (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr_i   (psel_wr),
        .sel_data_i (wr_data_i[1:0]),
        .tick_o     (tick_o)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic ch_wr;
        assign ch_wr = wr_en_i && (wr_addr_i[ADDR_W-1:3] == CH_IDX_W'(n));

        tmr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_o),
            .wr_i      (ch_wr),
            .wr_ofs_i  (wr_addr_i[2:0]),
            .wr_data_i (wr_data_i),
            .count_o   (count_o[n*16 +: 16]),
            .ovf_o     (ovf_o[n])
        );
    end

endmodule

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick_o;
    logic [31:0] count_o;
    logic [1:0]  ovf_o;

    int n_tests = 0;
    int n_fail = 0;
    int nt0 = 0, nt1 = 0;
    bit en0 = 0, en1 = 0;

    always #4 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .tick_o(tick_o), .count_o(count_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  psel;
        logic [15:0] init;
        logic [15:0] rld;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 2'd0, 16'hFFFE, 16'h1234, 16'd40},  // R3 reload
        '{2'd1, 2'd1, 16'hFFF0, 16'h7777, 16'd400}, // R4 wrap
        '{2'd2, 2'd0, 16'h55FC, 16'h00F0, 16'd60},  // R5 8-bit reload
        '{2'd0, 2'd2, 16'h0000, 16'hABCD, 16'd640}, // R3 no overflow, R1 /64
        '{2'd3, 2'd0, 16'h3C3C, 16'h0000, 16'd40},  // R6 hold
        '{2'd1, 2'd3, 16'h0100, 16'h0000, 16'd80}   // R1 code 11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (en0 && tick_o) nt0++;
        if (en1 && tick_o) nt1++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            if (en0 && tick_o) nt0++;
            if (en1 && tick_o) nt1++;
            @(negedge clk);
        end
    endtask

    task automatic wait_tick();
        while (!tick_o) @(negedge clk);
    endtask

    function automatic logic [16:0] mstep(input logic [1:0] m, input logic [15:0] c,
                                          input logic [15:0] r);
        case (m)
            2'd0: return (c == 16'hFFFF) ? {1'b1, r} : {1'b0, c + 16'd1};
            2'd1: return {(c == 16'hFFFF), c + 16'd1};
            2'd2: return (c[7:0] == 8'hFF) ? {1'b1, c[15:8], r[7:0]}
                                           : {1'b0, c[15:8], c[7:0] + 8'd1};
            default: return {1'b0, c};
        endcase
    endfunction

    function automatic int divof(input logic [1:0] p);
        return (p == 2'd1) ? 16 : (p == 2'd2) ? 64 : 4;
    endfunction

    initial begin
        #(8ns * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 count", count_o, 32'h0);
        chk("R10 ovf", {30'h0, ovf_o}, 32'h0);

        // R1 tick period for each select code
        for (int p = 0; p < 4; p++) begin
            int gap;
            wr(4'h0, 8'(p));
            wait_tick();
            @(negedge clk);
            gap = 1;
            while (!tick_o) begin @(negedge clk); gap++; end
            chk("R1 tick period", gap, divof(2'(p)));
        end

        // Vector table: both channels identical (R2)
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            logic [15:0] ec0, ec1;
            logic eo0, eo1;
            logic [16:0] r;
            int lo;
            t = VECS[v];
            wr(4'h0, {6'h0, t.psel});
            for (int ch = 0; ch < 2; ch++) begin
                wr(4'(ch*8+1), {5'h0, t.mode, 1'b0});
                wr(4'(ch*8+2), t.init[7:0]);
                wr(4'(ch*8+3), t.init[15:8]);
                wr(4'(ch*8+4), t.rld[7:0]);
                wr(4'(ch*8+5), t.rld[15:8]);
            end
            nt0 = 0; nt1 = 0;
            wr(4'h1, {5'h0, t.mode, 1'b1}); en0 = 1;
            wr(4'h9, {5'h0, t.mode, 1'b1}); en1 = 1;
            idle(int'(t.cyc));
            wr(4'h1, {5'h0, t.mode, 1'b0} | 8'h08); en0 = 0;
            wr(4'h9, {5'h0, t.mode, 1'b0} | 8'h08); en1 = 0;
            ec0 = t.init; eo0 = 0;
            for (int k = 0; k < nt0; k++) begin
                r = mstep(t.mode, ec0, t.rld); ec0 = r[15:0]; eo0 |= r[16];
            end
            ec1 = t.init; eo1 = 0;
            for (int k = 0; k < nt1; k++) begin
                r = mstep(t.mode, ec1, t.rld); ec1 = r[15:0]; eo1 |= r[16];
            end
            lo = (int'(t.cyc) + 2) / divof(t.psel);
            chk("R1 tick count", 32'((nt0 >= lo && nt0 <= lo + 1) ? 1 : 0), 32'd1);
            chk("R2/R3-R6 ch0 count", {16'h0, count_o[15:0]}, {16'h0, ec0});
            chk("R2/R3-R6 ch1 count", {16'h0, count_o[31:16]}, {16'h0, ec1});
            chk("R3 R4 R5 ch0 ovf", {31'h0, ovf_o[0]}, {31'h0, eo0});
            chk("R3 R4 R5 ch1 ovf", {31'h0, ovf_o[1]}, {31'h0, eo1});
        end

        // R8: wrap and clearing write in the same cycle -> set wins
        wr(4'h0, 8'h00);
        wr(4'h1, 8'h02);
        wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);
        wr(4'h1, 8'h03);
        wait_tick();
        wr(4'h1, 8'h03);
        chk("R8 set wins over clear", {31'h0, ovf_o[0]}, 32'h1);
        chk("R4 wrap to zero", {16'h0, count_o[15:0]}, 32'h0);
        wr(4'h1, 8'h02);
        chk("R8 clear by writing 0", {31'h0, ovf_o[0]}, 32'h0);
        wr(4'h1, 8'h0A);
        chk("R8 writing 1 no effect", {31'h0, ovf_o[0]}, 32'h0);

        // R9: count write on a tick cycle replaces the byte, no increment
        wr(4'hB, 8'h12); wr(4'hA, 8'h00);
        wr(4'h9, 8'h03);
        wait_tick();
        wr(4'hA, 8'h77);
        chk("R9 write overrides step", {16'h0, count_o[31:16]}, 32'h1277);
        wr(4'h9, 8'h02);

        // R7: stopped channel holds
        wr(4'h2, 8'h21); wr(4'h3, 8'h43);
        idle(50);
        chk("R7 stopped holds", {16'h0, count_o[15:0]}, 32'h4321);

        // R11: unused offsets change nothing
        wr(4'h6, 8'hFF); wr(4'h7, 8'hFF); wr(4'hE, 8'hFF);
        chk("R11 unused offset ch0", {16'h0, count_o[15:0]}, 32'h4321);
        chk("R11 unused offset ovf", {30'h0, ovf_o}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule